// File: doc/BRIEF.md
# DC Fault Ride-Through Mode Sequencer

This block decides which operating mode the grid-side converter runs in while a dc bus fault occurs and after it clears. Once per switching period it receives a sample of the dc current and a sample of the dc bus voltage. It compares them with programmable limits and moves through six modes. In run mode phase shift regulates current. In trip mode every gate is blocked. In settle mode the block waits one switching period. In fault-feed mode a controlled current is driven into the fault. In park mode the gates are blocked again. In resume mode the bus is brought back up.

In fault-feed mode the block sets a flag that swaps the control variables: duty then regulates current and phase shift regulates arm voltage. It also sets a second flag that bypasses the half-bridge cells and runs the full-bridge cells bipolar. The fault-feed interval is counted in switching periods. A sticky history register records every mode entered. The history clears only when the clear input is pulsed.

Top module: `frt_mode_seq`

## Requirements
- R1: After reset the mode is run (code 0). `gate_block`, `ctrl_swap` and `fb_bipolar` are low, and the history is all zero.
- R2: In run (0) or resume (5), a valid sample whose current is strictly greater than `oc_limit` raises `gate_block` in that same cycle. The mode is trip (1) in the next cycle. A current equal to the limit does not trip.
- R3: Trip (1) holds until a valid sample whose voltage is strictly below `safe_limit`. The mode is then settle (2) in the next cycle.
- R4: Settle (2) moves to fault-feed (3) on the next valid sample, that is, one switching period later.
- R5: In fault-feed (3), `ctrl_swap` and `fb_bipolar` are high and `gate_block` is low. Overcurrent samples have no effect there. On the `hold_len`-th valid sample the mode becomes park (4). A `hold_len` of 0 acts as 1.
- R6: Park (4) ignores samples and moves to resume (5) in the cycle after `clear_cmd` is high. In every other mode `clear_cmd` has no effect.
- R7: In resume (5) the gates are enabled and `ctrl_swap` is low. A valid sample with voltage at or above `v_arm_ref` returns the mode to run (0).
- R8: In resume, if one sample both exceeds `oc_limit` and reaches `v_arm_ref`, the overcurrent wins and the next mode is trip (1).
- R9: A cycle with `smp_valid` low changes no mode. The only exception is the park-to-resume move of R6.
- R10: History bit k (mode code k, 6 bits) is set when mode k is entered and stays set. `hist_clr` zeroes the history, except that a mode entered in the same cycle keeps its bit.
- R11: `gate_block` is high throughout trip (1), settle (2) and park (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| smp_valid | input | 1 | One pulse per switching period marking a fresh sample |
| i_dc_smp | input | DW | Sampled dc current magnitude |
| v_dc_smp | input | DW | Sampled dc bus voltage |
| v_arm_ref | input | DW | Arm voltage level at which the bus counts as recovered |
| oc_limit | input | DW | Overcurrent limit |
| safe_limit | input | DW | Safe bus voltage limit |
| hold_len | input | HW | Fault-feed interval in switching periods |
| clear_cmd | input | 1 | Fault located and isolated; permits resume |
| hist_clr | input | 1 | Clears the sticky history |
| mode_o | output | 3 | Current mode code (0 run, 1 trip, 2 settle, 3 fault-feed, 4 park, 5 resume) |
| gate_block | output | 1 | Blocks all converter gates |
| ctrl_swap | output | 1 | Duty regulates current, phase shift regulates arm voltage |
| fb_bipolar | output | 1 | Half-bridge cells bypassed, full-bridge cells bipolar |
| hist_o | output | 6 | Sticky record of modes entered |

## Verification
Two pairs of events can land in the same cycle. The first pair is the overcurrent trip and the recovery exit in resume. The bench provokes this with one sample that is above `oc_limit` and also at or above `v_arm_ref`, and it expects the next mode to be trip. The second pair is a history clear and a mode entry. The bench pulses `hist_clr` on the cycle that enters a new mode, and it expects only the new mode's bit to remain. A behavioural model in the bench predicts every output on every cycle, including the same-cycle `gate_block` rise on a tripping sample.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int NMODES = 6;
  localparam int MW     = 3;

  typedef enum logic [MW-1:0] {
    FM_RUN    = 3'd0,
    FM_TRIP   = 3'd1,
    FM_SETTLE = 3'd2,
    FM_FEED   = 3'd3,
    FM_PARK   = 3'd4,
    FM_RESUME = 3'd5
  } frt_mode_e;
endpackage

// File: rtl/frt_limit_cmp.sv
module frt_limit_cmp #(
  parameter int DW = 12
) (
  input  logic          smp_valid,
  input  logic [DW-1:0] i_dc,
  input  logic [DW-1:0] v_dc,
  input  logic [DW-1:0] v_arm,
  input  logic [DW-1:0] oc_lim,
  input  logic [DW-1:0] safe_lim,
  output logic          over_i,
  output logic          low_v,
  output logic          back_v
);
  always_comb begin
    over_i = smp_valid && (i_dc > oc_lim);
    low_v  = smp_valid && (v_dc < safe_lim);
    back_v = smp_valid && (v_dc >= v_arm);
  end
endmodule

// File: rtl/frt_hold_timer.sv
module frt_hold_timer #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [HW-1:0] len,
  output logic          done
);
  localparam int CW = HW + 1;

  logic [HW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [CW-1:0] len_eff;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    len_eff = (len == '0) ? CW'(1) : {1'b0, len};
    cnt_nxt = {1'b0, cnt_q} + CW'(1);
    done    = run && tick && (cnt_nxt >= len_eff);
    cnt_en  = !run || tick;
    cnt_d   = run ? cnt_nxt[HW-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/frt_mode_hist.sv
module frt_mode_hist #(
  parameter int N  = 6,
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter,
  input  logic [MW-1:0] enter_mode,
  input  logic          clr,
  output logic [N-1:0]  hist
);
  logic [N-1:0] hist_q, hist_d;

  for (genvar k = 0; k < N; k++) begin : g_bit
    logic hit;
    always_comb begin
      hit = enter && (enter_mode == MW'(k));
      if (hit)      hist_d[k] = 1'b1;
      else if (clr) hist_d[k] = 1'b0;
      else          hist_d[k] = hist_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else if (enter || clr) hist_q <= hist_d;
  end

  assign hist = hist_q;
endmodule

// File: rtl/frt_mode_seq.sv
module frt_mode_seq
  import frt_pkg::*;
#(
  parameter int DW = 12,
  parameter int HW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [DW-1:0]    i_dc_smp,
  input  logic [DW-1:0]    v_dc_smp,
  input  logic [DW-1:0]    v_arm_ref,
  input  logic [DW-1:0]    oc_limit,
  input  logic [DW-1:0]    safe_limit,
  input  logic [HW-1:0]    hold_len,
  input  logic             clear_cmd,
  input  logic             hist_clr,
  output logic [MW-1:0]    mode_o,
  output logic             gate_block,
  output logic             ctrl_swap,
  output logic             fb_bipolar,
  output logic [NMODES-1:0] hist_o
);
  frt_mode_e st_q, st_d;
  logic over_i, low_v, back_v, hold_done, st_chg;

  frt_limit_cmp #(.DW(DW)) u_cmp (
    .smp_valid (smp_valid),
    .i_dc      (i_dc_smp),
    .v_dc      (v_dc_smp),
    .v_arm     (v_arm_ref),
    .oc_lim    (oc_limit),
    .safe_lim  (safe_limit),
    .over_i    (over_i),
    .low_v     (low_v),
    .back_v    (back_v)
  );

  frt_hold_timer #(.HW(HW)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (st_q == FM_FEED),
    .tick  (smp_valid),
    .len   (hold_len),
    .done  (hold_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FM_RUN:    if (over_i) st_d = FM_TRIP;
      FM_TRIP:   if (low_v) st_d = FM_SETTLE;
      FM_SETTLE: if (smp_valid) st_d = FM_FEED;
      FM_FEED:   if (hold_done) st_d = FM_PARK;
      FM_PARK:   if (clear_cmd) st_d = FM_RESUME;
      FM_RESUME: begin
        if (over_i)      st_d = FM_TRIP;
        else if (back_v) st_d = FM_RUN;
      end
      default:   st_d = FM_TRIP;
    endcase
    st_chg = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FM_RUN;
    else if (st_chg) st_q <= st_d;
  end

  frt_mode_hist #(.N(NMODES), .MW(MW)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter      (st_chg),
    .enter_mode (st_d),
    .clr        (hist_clr),
    .hist       (hist_o)
  );

  always_comb begin
    mode_o     = st_q;
    ctrl_swap  = (st_q == FM_FEED);
    fb_bipolar = (st_q == FM_FEED);
    gate_block = (st_q == FM_TRIP) || (st_q == FM_SETTLE) || (st_q == FM_PARK)
              || (((st_q == FM_RUN) || (st_q == FM_RESUME)) && over_i);
  end
endmodule

// File: rtl/frt_mode_seq_chk.sv
module frt_mode_seq_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic [DW-1:0] i_dc_smp,
  input logic [DW-1:0] v_dc_smp,
  input logic [DW-1:0] v_arm_ref,
  input logic [DW-1:0] oc_limit,
  input logic          clear_cmd,
  input logic          hist_clr,
  input logic [2:0]    mode_o,
  input logic          gate_block,
  input logic          ctrl_swap,
  input logic [5:0]    hist_o
);
  logic trip_smp;
  assign trip_smp = smp_valid && (i_dc_smp > oc_limit)
                 && ((mode_o == 3'd0) || (mode_o == 3'd5));

  p_trip_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trip_smp |-> gate_block);
  p_trip_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trip_smp |=> (mode_o == 3'd1));
  p_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd2 && smp_valid) |=> (mode_o == 3'd3));
  p_swap_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_swap) |-> ($past(mode_o) == 3'd2) && !gate_block);
  p_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4 && !clear_cmd) |=> (mode_o == 3'd4) && gate_block);
  p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd5 && smp_valid && (i_dc_smp > oc_limit) && (v_dc_smp >= v_arm_ref))
      |=> (mode_o == 3'd1));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !clear_cmd) |=> $stable(mode_o));
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hist_clr |=> ((hist_o & $past(hist_o)) == $past(hist_o)));
  p_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd1 || mode_o == 3'd2) |-> gate_block);
endmodule

bind frt_mode_seq frt_mode_seq_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_valid  (smp_valid),
  .i_dc_smp   (i_dc_smp),
  .v_dc_smp   (v_dc_smp),
  .v_arm_ref  (v_arm_ref),
  .oc_limit   (oc_limit),
  .clear_cmd  (clear_cmd),
  .hist_clr   (hist_clr),
  .mode_o     (mode_o),
  .gate_block (gate_block),
  .ctrl_swap  (ctrl_swap),
  .hist_o     (hist_o)
);

// File: tb/frt_mode_seq_tb.sv
module frt_mode_seq_tb;
  localparam int DW = 12;
  localparam int HW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic [DW-1:0] i_dc_smp = '0, v_dc_smp = '0;
  logic [DW-1:0] v_arm_ref = 12'd250, oc_limit = 12'd180, safe_limit = 12'd25;
  logic [HW-1:0] hold_len = 16'd3;
  logic          clear_cmd = 1'b0, hist_clr = 1'b0;
  logic [2:0]    mode_o;
  logic          gate_block, ctrl_swap, fb_bipolar;
  logic [5:0]    hist_o;

  int n_vec = 0, n_bad = 0, cyc = 0;
  int ms = 0, mcnt = 0;
  bit [5:0] mh = '0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  frt_mode_seq #(.DW(DW), .HW(HW)) u_dut (.*);

  task automatic model_adv();
    int nxt = ms;
    bit oc   = smp_valid && (i_dc_smp > oc_limit);
    int hold = (hold_len == 0) ? 1 : int'(hold_len);
    case (ms)
      0: if (oc) nxt = 1;
      1: if (smp_valid && v_dc_smp < safe_limit) nxt = 2;
      2: if (smp_valid) begin nxt = 3; mcnt = 0; end
      3: if (smp_valid) begin mcnt++; if (mcnt >= hold) nxt = 4; end
      4: if (clear_cmd) nxt = 5;
      5: if (oc) nxt = 1; else if (smp_valid && v_dc_smp >= v_arm_ref) nxt = 0;
      default: nxt = 1;
    endcase
    if (hist_clr) mh = '0;
    if (nxt != ms) mh[nxt] = 1'b1;
    ms = nxt;
  endtask

  task automatic compare();
    bit eg = (ms == 1) || (ms == 2) || (ms == 4) ||
             (((ms == 0) || (ms == 5)) && smp_valid && (i_dc_smp > oc_limit));
    bit es = (ms == 3);
    n_vec++;
    if (mode_o !== 3'(ms) || gate_block !== eg || ctrl_swap !== es ||
        fb_bipolar !== es || hist_o !== mh) begin
      n_bad++;
      $display("FAIL %s cyc %0d: mode/gb/sw/fb/hist got %0d/%0b/%0b/%0b/%b exp %0d/%0b/%0b/%0b/%b",
               cur_req, cyc, mode_o, gate_block, ctrl_swap, fb_bipolar, hist_o,
               ms, eg, es, es, mh);
    end
  endtask

  task automatic step(input bit v, input int i, input int vd,
                      input bit clr = 0, input bit hc = 0);
    @(negedge clk);
    cyc++;
    if (rst_n) model_adv();
    smp_valid = v; i_dc_smp = DW'(i); v_dc_smp = DW'(vd);
    clear_cmd = clr; hist_clr = hc;
    #1 compare();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 250);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: expired, exp completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    cur_req = "R1";
    for (int k = 0; k < 3; k++) step(0, 0, 250);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    cur_req = "R9";
    step(0, 999, 0); step(0, 999, 0, 1);
    cur_req = "R2";
    step(1, 180, 250); step(1, 100, 250);
    step(1, 181, 250);
    cur_req = "R3";
    step(1, 0, 200); step(1, 0, 25); step(0, 0, 0); step(1, 0, 24);
    cur_req = "R4";
    step(0, 0, 10); step(0, 0, 10); step(1, 0, 10);
    cur_req = "R5";
    step(1, 999, 10); step(0, 999, 10); step(1, 999, 10); step(1, 0, 10);
    cur_req = "R6";
    step(1, 999, 5); step(1, 0, 300); step(0, 0, 5, 1);
    cur_req = "R7";
    step(1, 10, 100); step(1, 10, 249); step(0, 10, 260); step(1, 10, 250);
    cur_req = "R10";
    idle(1); step(0, 0, 250, 0, 1); idle(1);
    cur_req = "R8";
    hold_len = 16'd0;
    step(1, 200, 250); step(1, 0, 10); step(1, 0, 10);
    step(1, 0, 10, 0, 1);
    step(1, 0, 10); step(0, 0, 10, 1);
    step(1, 300, 260);
    cur_req = "R11";
    step(1, 0, 100); step(1, 0, 100); step(1, 0, 3); step(0, 0, 3);
    cur_req = "R5";
    hold_len = 16'd5;
    for (int k = 0; k < 6; k++) step(1, 500, 3);
    step(0, 0, 3, 1); step(1, 0, 260, 0, 1);
    idle(3);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule